// File: doc/BRIEF.md
# Return Address Stack Cache

This block keeps the top of a core's return address stack on chip. The core pushes a 16-bit return address on a call and pops one on a return. Both are served from a small ring of internal entries. Behind the core's back, the block moves entries between the ring and a backing stack in external memory. When the ring runs high, the oldest entries are written out. When it runs low and memory still holds older entries, those entries are read back in below the oldest cached one. Moves start at thresholds a quarter of the depth away from either end and run until the ring is half full. This hysteresis keeps the number of cached entries near the middle, so bursts of calls or returns rarely wait.

The core supplies its architectural stack pointer on `sp_i`. This is the byte address of the current top entry, and the stack grows downward. The block derives every memory address from `sp_i` and its own occupancy. Each memory access is one byte wide and is tagged with the return-stack function code. A request is held until the memory acknowledges it. When a request cannot be served this cycle, the core sees `stall_o` and repeats the request.

Top module: `ret_stack_cache`

## Requirements
- R1: After reset the ring is empty, the backing stack is empty, no memory request is raised, and a push is accepted without stall.
- R2: Every accepted pop returns on `pop_data_o` the most recently pushed address that has not been popped yet. This holds across any number of spills and fills.
- R3: When no transfer is in progress and occupancy exceeds DEPTH - DEPTH/4 (6 for DEPTH 8), a spill write request is raised in the next cycle.
- R4: Once a spill run has begun, entries keep being spilled until occupancy is DEPTH/2 (4 for DEPTH 8). The block then goes quiet.
- R5: When no transfer is in progress, occupancy is below DEPTH/4 (2 for DEPTH 8) and the backing stack is not empty, a fill read request is raised in the next cycle. Fills continue until occupancy is DEPTH/2 or the backing stack is empty.
- R6: No fill read is ever issued while the backing stack holds no entries.
- R7: A push stalls exactly when the ring holds DEPTH entries, or when it holds DEPTH-1 entries while a fill is in progress.
- R8: A pop stalls exactly when the ring holds no entries, or when it holds one entry while a spill is in progress.
- R9: Every memory request carries function code 3'b011 on `mem_fc_o`.
- R10: The entry at depth k below the top lives at byte address `sp_i` + 2k. Its high byte is at that address and its low byte at the next one. A spill writes the oldest cached entry, high byte first, then low byte. A fill reads the entry just below the oldest cached one in the same order.
- R11: If push and pop are requested in the same cycle, only the push is acted on. The pop is ignored, and the pushed value is what the next pop returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Return address to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 16 | Top return address, valid on an accepted pop |
| stall_o | output | 1 | Request not taken this cycle |
| sp_i | input | 16 | Byte address of the current top entry (stack grows down) |
| mem_req_o | output | 1 | Memory byte request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_fc_o | output | 3 | Address function code |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with the acknowledge |
| mem_ack_i | input | 1 | One-cycle acknowledge of the pending byte |

## Verification
By default the bench builds the block with DEPTH 8, so the spill threshold is 6, the fill threshold is 2 and the target is 4. Its directed sequences are written in terms of DEPTH. They can be rebuilt with DEPTH 32, which exercises the 24/8/16 thresholds and a wider occupancy counter. Memory latency is varied from zero to several cycles. The zero setting shows threshold timing cleanly. The slow setting lets back-to-back pushes reach a full ring and back-to-back pops reach an empty one, which brings both stall rules and concurrent push/pop during transfers within reach.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int ENTRY_W = 16;
  localparam logic [2:0] FC_RET_STACK = 3'b011;

  typedef enum logic [2:0] {
    X_IDLE,
    X_SP_HI,
    X_SP_LO,
    X_FL_HI,
    X_FL_LO
  } xfer_e;
endpackage

// File: rtl/rsc_store.sv
module rsc_store #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             fill_i,
  input  logic [W-1:0]     fill_data_i,
  input  logic             spill_i,
  output logic [W-1:0]     top_o,
  output logic [W-1:0]     oldest_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     ring_q [DEPTH];
  logic [PTR_W-1:0] free_q, top_idx, old_idx, fill_idx;
  logic [CNT_W-1:0] cnt_q;

  // free_q: next free slot; oldest cached entry sits cnt_q slots below it
  assign top_idx  = free_q - PTR_W'(1);
  assign old_idx  = free_q - PTR_W'(cnt_q);
  assign fill_idx = old_idx - PTR_W'(1);

  assign top_o    = ring_q[top_idx];
  assign oldest_o = ring_q[old_idx];
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) ring_q[free_q]  <= push_data_i;
    if (fill_i) ring_q[fill_idx] <= fill_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= '0;
      cnt_q  <= '0;
    end else begin
      free_q <= free_q + PTR_W'(push_i) - PTR_W'(pop_i);
      cnt_q  <= cnt_q + CNT_W'(push_i) + CNT_W'(fill_i)
                      - CNT_W'(pop_i) - CNT_W'(spill_i);
    end
  end
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int EXT_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [AW-1:0]      sp_i,
  input  logic [ENTRY_W-1:0] oldest_i,
  input  logic [7:0]         mem_rdata_i,
  input  logic               mem_ack_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               spill_o,
  output logic               fill_o,
  output logic [ENTRY_W-1:0] fill_data_o,
  output logic               spill_busy_o,
  output logic               fill_busy_o,
  output logic               lo_byte_o,
  output logic [EXT_W-1:0]   ext_o
);
  localparam logic [CNT_W-1:0] HI_MARK  = CNT_W'(DEPTH - DEPTH / 4);
  localparam logic [CNT_W-1:0] LO_MARK  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] MID_MARK = CNT_W'(DEPTH / 2);

  xfer_e            state_q, state_d;
  logic             run_sp_q, run_sp_d, run_fl_q, run_fl_d;
  logic [7:0]       hi_q;
  logic [EXT_W-1:0] ext_q;
  logic             spilling, filling, lo_byte, want_spill, want_fill;
  logic [CNT_W-1:0] slot;

  assign spilling = (state_q == X_SP_HI) || (state_q == X_SP_LO);
  assign filling  = (state_q == X_FL_HI) || (state_q == X_FL_LO);
  assign lo_byte  = (state_q == X_SP_LO) || (state_q == X_FL_LO);

  // spill: oldest cached entry (depth cnt-1); fill: entry just below it (depth cnt)
  assign slot       = spilling ? cnt_i - CNT_W'(1) : cnt_i;
  assign mem_addr_o = sp_i + (AW'(slot) << 1) + AW'(lo_byte);

  assign mem_req_o    = state_q != X_IDLE;
  assign mem_we_o     = spilling;
  assign mem_wdata_o  = lo_byte ? oldest_i[7:0] : oldest_i[15:8];
  assign spill_o      = (state_q == X_SP_LO) && mem_ack_i;
  assign fill_o       = (state_q == X_FL_LO) && mem_ack_i;
  assign fill_data_o  = {hi_q, mem_rdata_i};
  assign spill_busy_o = spilling;
  assign fill_busy_o  = filling;
  assign lo_byte_o    = lo_byte;
  assign ext_o        = ext_q;

  // hysteresis: a run started at a quarter mark continues to the middle
  assign want_spill = (cnt_i > HI_MARK) || (run_sp_q && cnt_i > MID_MARK);
  assign want_fill  = (ext_q != '0) &&
                      ((cnt_i < LO_MARK) || (run_fl_q && cnt_i < MID_MARK));

  always_comb begin
    state_d  = state_q;
    run_sp_d = run_sp_q;
    run_fl_d = run_fl_q;
    unique case (state_q)
      X_IDLE: begin
        if (want_spill) begin
          state_d  = X_SP_HI;
          run_sp_d = 1'b1;
          run_fl_d = 1'b0;
        end else if (want_fill) begin
          state_d  = X_FL_HI;
          run_fl_d = 1'b1;
          run_sp_d = 1'b0;
        end else begin
          run_sp_d = 1'b0;
          run_fl_d = 1'b0;
        end
      end
      X_SP_HI: if (mem_ack_i) state_d = X_SP_LO;
      X_SP_LO: if (mem_ack_i) state_d = X_IDLE;
      X_FL_HI: if (mem_ack_i) state_d = X_FL_LO;
      X_FL_LO: if (mem_ack_i) state_d = X_IDLE;
      default: state_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= X_IDLE;
      run_sp_q <= 1'b0;
      run_fl_q <= 1'b0;
      hi_q     <= '0;
      ext_q    <= '0;
    end else begin
      state_q  <= state_d;
      run_sp_q <= run_sp_d;
      run_fl_q <= run_fl_d;
      if (state_q == X_FL_HI && mem_ack_i) hi_q <= mem_rdata_i;
      ext_q    <= ext_q + EXT_W'(spill_o) - EXT_W'(fill_o);
    end
  end
endmodule

// File: rtl/ret_stack_cache.sv
module ret_stack_cache
  import rsc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int EXT_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [15:0] push_data_i,
  input  logic        pop_i,
  output logic [15:0] pop_data_o,
  output logic        stall_o,
  input  logic [15:0] sp_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [2:0]  mem_fc_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic        mem_ack_i
);
  logic [CNT_W-1:0]   cnt;
  logic [EXT_W-1:0]   ext_cnt;
  logic [ENTRY_W-1:0] oldest, fill_data;
  logic               spill_done, fill_done, spill_busy, fill_busy, lo_byte;
  logic               push_block, pop_block, push_go, pop_go, pop_req;

  assign pop_req    = pop_i && !push_i;  // push wins a simultaneous request
  assign push_block = (cnt == CNT_W'(DEPTH)) ||
                      (fill_busy && cnt == CNT_W'(DEPTH - 1));
  assign pop_block  = (cnt == '0) || (spill_busy && cnt == CNT_W'(1));
  assign push_go    = push_i && !push_block;
  assign pop_go     = pop_req && !pop_block;
  assign stall_o    = (push_i && push_block) || (pop_req && pop_block);
  assign mem_fc_o   = FC_RET_STACK;

  rsc_store #(
    .DEPTH(DEPTH),
    .W    (ENTRY_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_go),
    .pop_i      (pop_go),
    .push_data_i(push_data_i),
    .fill_i     (fill_done),
    .fill_data_i(fill_data),
    .spill_i    (spill_done),
    .top_o      (pop_data_o),
    .oldest_o   (oldest),
    .cnt_o      (cnt)
  );

  rsc_ctrl #(
    .DEPTH(DEPTH),
    .AW   (16),
    .EXT_W(EXT_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt),
    .sp_i        (sp_i),
    .oldest_i    (oldest),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .spill_o     (spill_done),
    .fill_o      (fill_done),
    .fill_data_o (fill_data),
    .spill_busy_o(spill_busy),
    .fill_busy_o (fill_busy),
    .lo_byte_o   (lo_byte),
    .ext_o       (ext_cnt)
  );
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int DEPTH = 8,
  parameter int EXT_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             stall_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [15:0]      mem_addr_o,
  input logic             lo_byte_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [EXT_W-1:0] ext_i
);
  // R3
  spill_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && cnt_i > CNT_W'(DEPTH - DEPTH / 4)) |=> (mem_req_o && mem_we_o));

  // R6
  no_empty_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (ext_i != '0));

  // R7
  full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_i == CNT_W'(DEPTH)) |-> stall_o);

  // R7
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_i == '0) |-> stall_o);

  // R10
  byte_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !lo_byte_i) |=>
      (mem_req_o && lo_byte_i && mem_we_o == $past(mem_we_o) &&
       mem_addr_o == $past(mem_addr_o) + 16'd1));
endmodule

bind ret_stack_cache rsc_chk #(
  .DEPTH(DEPTH),
  .EXT_W(EXT_W)
) i_rsc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .stall_o   (stall_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_ack_i (mem_ack_i),
  .mem_addr_o(mem_addr_o),
  .lo_byte_i (lo_byte),
  .cnt_i     (cnt),
  .ext_i     (ext_cnt)
);

// File: tb/test_ret_stack_cache.sv
`timescale 1ns/1ps
module test_ret_stack_cache;
  parameter int DEPTH = 8;
  localparam int HI  = DEPTH - DEPTH / 4;
  localparam int LO  = DEPTH / 4;
  localparam int MID = DEPTH / 2;
  localparam int S0  = 'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [15:0] push_data_i = '0, sp_i = 16'(S0);
  logic [15:0] pop_data_o;
  logic        stall_o;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [2:0]  mem_fc_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i = '0;

  always #4 clk = ~clk;

  ret_stack_cache #(.DEPTH(DEPTH)) i_ret_stack_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .stall_o(stall_o),
    .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_fc_o(mem_fc_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  int          checks = 0, fails = 0;
  logic [15:0] stk[$];      // whole architectural stack, index 0 = bottom
  int          ext_m = 0;   // entries held in memory
  int          lat = 0, wait_c = 0;
  bit          ack_r = 0, sp_ph = 0, fl_ph = 0;
  bit          due_spill = 0, due_fill = 0;
  bit          accepted = 0, saw_push_stall = 0, saw_pop_stall = 0, done = 0;
  logic [15:0] last_pop = '0;
  logic [7:0]  bmem [int];

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(bit pu, bit po, logic [15:0] d);
    int  cnt, a;
    bit  sdone, fdone, exp_stall, spb, flb;
    @(negedge clk);
    cnt = stk.size() - ext_m;
    if (due_spill) chk(mem_req_o && mem_we_o, "R3", "spill start", int'(mem_req_o), 1);
    if (due_fill)  chk(mem_req_o && !mem_we_o, "R5", "fill start", int'(mem_req_o), 1);
    if (mem_req_o) chk(mem_fc_o == 3'b011, "R9", "function code", int'(mem_fc_o), 3);
    if (mem_req_o && !mem_we_o) chk(ext_m > 0, "R6", "fill with empty memory", ext_m, 1);
    push_i = pu; pop_i = po; push_data_i = d;
    sp_i = 16'(S0 - 2 * stk.size());
    #1;
    sdone = 0; fdone = 0;
    if (mem_req_o && !ack_r) begin
      if (wait_c <= 0) begin
        ack_r = 1; wait_c = lat;
        if (mem_we_o) begin
          a = S0 - 2 * ext_m - 2 + int'(sp_ph);
          chk(mem_addr_o == 16'(a), "R10", "spill address", int'(mem_addr_o), a);
          chk(mem_wdata_o == (sp_ph ? stk[ext_m][7:0] : stk[ext_m][15:8]), "R10",
              "spill byte", int'(mem_wdata_o), int'(sp_ph ? stk[ext_m][7:0] : stk[ext_m][15:8]));
          bmem[a] = mem_wdata_o;
          if (sp_ph) sdone = 1;
          sp_ph = ~sp_ph;
        end else begin
          a = S0 - 2 * ext_m + int'(fl_ph);
          chk(mem_addr_o == 16'(a), "R10", "fill address", int'(mem_addr_o), a);
          mem_rdata_i = bmem.exists(a) ? bmem[a] : 8'h00;
          if (fl_ph) fdone = 1;
          fl_ph = ~fl_ph;
        end
      end else wait_c--;
    end else begin
      ack_r = 0; wait_c = lat;
    end
    mem_ack_i = ack_r;
    #1;
    spb = mem_req_o && mem_we_o;
    flb = mem_req_o && !mem_we_o;
    if (pu) exp_stall = (cnt == DEPTH) || (flb && cnt == DEPTH - 1);
    else if (po) exp_stall = (cnt == 0) || (spb && cnt == 1);
    else exp_stall = 0;
    chk(stall_o == exp_stall, (pu && po) ? "R11" : pu ? "R7" : "R8", "stall",
        int'(stall_o), int'(exp_stall));
    if (pu && exp_stall) saw_push_stall = 1;
    if (po && !pu && exp_stall) saw_pop_stall = 1;
    accepted = (pu || po) && !exp_stall;
    if (po && !pu && accepted) begin
      chk(pop_data_o == stk[$], "R2", "pop value", int'(pop_data_o), int'(stk[$]));
      last_pop = pop_data_o;
    end
    due_spill = !mem_req_o && cnt > HI;
    due_fill  = !mem_req_o && cnt < LO && ext_m > 0;
    if (sdone) ext_m++;
    if (fdone) ext_m--;
    if (accepted) begin
      if (pu) stk.push_back(d);
      else void'(stk.pop_back());
    end
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 16'h0);
  endtask

  task automatic do_push(logic [15:0] d);
    accepted = 0;
    while (!accepted) cyc(1, 0, d);
  endtask

  task automatic do_pop();
    accepted = 0;
    while (!accepted) cyc(0, 1, 16'h0);
  endtask

  task automatic settle(string rq, int exp);
    idle(80);
    chk(!mem_req_o, rq, "quiet after settling", int'(mem_req_o), 0);
    chk(stk.size() - ext_m == exp, rq, "settled occupancy", stk.size() - ext_m, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int exp_fill, ext_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!mem_req_o, "R1", "no request after reset", int'(mem_req_o), 0);
    push_i = 1'b1; #1;
    chk(!stall_o, "R1", "push not stalled after reset", int'(stall_o), 0);
    push_i = 1'b0;

    // R3/R4: crossing the high mark spills down to the middle
    lat = 0;
    for (int i = 0; i <= HI; i++) do_push(16'hA000 + 16'(i));
    settle("R4", MID);
    ext_a = HI + 1 - MID;
    chk(ext_m == ext_a, "R4", "entries spilled", ext_m, ext_a);

    // R5: dropping below the low mark fills back
    for (int i = 0; i < MID - LO + 1; i++) do_pop();
    exp_fill = (LO - 1 + ext_a < MID) ? LO - 1 + ext_a : MID;
    settle("R5", exp_fill);
    while (stk.size() > 0) do_pop();

    // R6: low occupancy with empty memory stays quiet
    for (int i = 0; i < HI; i++) do_push(16'hB100 + 16'(i));
    for (int i = 0; i < HI - LO + 1; i++) do_pop();
    settle("R6", LO - 1);
    while (stk.size() > 0) do_pop();

    // R7/R8: slow memory, bursts hit full and empty
    lat = 6;
    for (int i = 0; i < 2 * DEPTH + 4; i++) cyc(1, 0, 16'hC200 + 16'(i));
    while (stk.size() < 2 * DEPTH + 4) do_push(16'hC300 + 16'(stk.size()));
    chk(saw_push_stall, "R7", "push stall on full ring", int'(saw_push_stall), 1);
    settle("R4", MID);
    while (stk.size() > 0) cyc(0, 1, 16'h0);
    chk(saw_pop_stall, "R8", "pop stall on empty ring", int'(saw_pop_stall), 1);

    // R11: simultaneous push and pop
    lat = 0;
    do_push(16'h1111);
    accepted = 0;
    while (!accepted) cyc(1, 1, 16'h1234);
    do_pop();
    chk(last_pop == 16'h1234, "R11", "pushed value wins", int'(last_pop), 'h1234);
    do_pop();
    chk(last_pop == 16'h1111, "R11", "older value kept", int'(last_pop), 'h1111);

    // R2: random mix under varying latency
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 100 == 0) lat = $urandom_range(0, 5);
      r = $urandom_range(0, 9);
      if (r < 4) cyc(1, 0, 16'($urandom));
      else if (r < 8 && stk.size() > 0) cyc(0, 1, 16'h0);
      else if (r == 8) cyc(1, 1, 16'($urandom));
      else cyc(0, 0, 16'h0);
    end
    while (stk.size() > 0) do_pop();
    settle("R2", 0);
    chk(ext_m == 0, "R2", "memory stack drained", ext_m, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule